// File: doc/BRIEF.md
# Programmable Frequency Generator Bank

This block holds six clock generators that share one fast system clock. Three source clocks arrive as single-cycle tick enables: the CPU clock, an auxiliary PLL and a second auxiliary PLL. Each generator selects one source and counts its ticks. After a programmed ratio of ticks it emits a one-cycle output tick and toggles a square-wave output. Software programs the generators through two 32-bit control words with a simple write port, and reads either word back through a combinational read port.

Two control word layouts exist, and the `EXTENDED` parameter picks one of them. The legacy layout has a one-bit source select, a separate enable bit and even-only division. The extended layout has a two-bit source mux in which code zero means off, plus a per-word scale bit. That scale bit chooses between even-only division and division by any integer. A change of ratio or source is held back until the running output period ends, so an output period is never cut short. Disabling a generator is the exception and acts at once.

Top module: `fgen_bank`

## Requirements
- R1: Generators 0, 1 and 2 are controlled by word 0, and generators 3, 4 and 5 by word 1. Each generator has a 10-bit field at bit offset 0, 10 or 20, in generator order. A field change affects only its own generator.
- R2: Legacy layout (`EXTENDED`=0). Field bit 0 picks the source (0 = CPU tick, 1 = auxiliary tick). Field bit 1 enables the generator. Field bits 9:2 hold N, and the ratio is (N+1)*2, so the largest ratio is 512.
- R3: Extended layout (`EXTENDED`=1). Field bits 1:0 are a mux with these codes: 0 = off, 1 = second auxiliary tick, 2 = CPU tick, 3 = auxiliary tick.
- R4: Extended layout only. Bit 30 of a control word is the scale bit for its three generators. When it is set, the ratio is N+1 (largest 256). When it is clear, the ratio is (N+1)*2.
- R5: `gen_tick` goes high for one cycle, in the cycle after the selected source tick that completes the ratio. With a source tick period P and a ratio R, output ticks are therefore spaced P*R cycles apart.
- R6: A generator whose field is disabled has both outputs low from the cycle after the write onward. Its count also restarts from zero, so after it is re-enabled on a source that ticks every cycle, the first output tick appears R+2 cycles after the write cycle.
- R7: A new ratio or source written to a running generator takes effect only after the current output period has finished.
- R8: `gen_wave` toggles on every output tick and on no other cycle while the generator is enabled.
- R9: With a ratio of 1, every source tick produces an output tick.
- R10: A control word reads back the last value written, except that reserved bits read as zero. Bit 31 is always reserved, and bit 30 is reserved in the legacy layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for a control word |
| wr_sel | input | 1 | Control word selected for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Control word selected for the read |
| rd_data | output | 32 | Read data, combinational |
| cpu_tick | input | 1 | CPU clock tick enable |
| aux_tick | input | 1 | Auxiliary PLL tick enable |
| aux2_tick | input | 1 | Second auxiliary PLL tick enable |
| gen_tick | output | 6 | Per-generator output tick |
| gen_wave | output | 6 | Per-generator square wave |

## Verification
A wrong count or a wrong latched ratio changes the spacing of output ticks, and this shows within one output period of the fault. The bench therefore measures spacing across sources of period 1, 3 and 5 cycles, and at the largest ratios. If the new limit is loaded too early, the period that contains the write comes out shortened. This is checked by writing a new ratio just after an output tick. If the count is not cleared on disable, the latency to the first tick after re-enable comes out wrong. A decode error in one field appears on a neighbouring generator's outputs, or in the read data, in the cycle right after the write.

// File: rtl/fgen_pkg.sv
package fgen_pkg;
   localparam int FIELD_W      = 10;
   localparam int DIV_W        = 8;
   localparam int CNT_W        = DIV_W + 1;
   localparam int GENS_PER_REG = 3;
   localparam int NUM_SRC      = 3;
   localparam int SRC_W        = 2;
   localparam int SCALE_BIT    = 30;

   // index of a source in the tick vector handed to each core
   typedef enum logic [SRC_W-1:0] {
      SRC_CPU  = 2'd0,
      SRC_AUX  = 2'd1,
      SRC_AUX2 = 2'd2
   } src_idx_e;
endpackage

// File: rtl/fgen_regs.sv
module fgen_regs #(
   parameter int  REG_W    = 32,
   parameter int  NUM_REG  = 2,
   parameter bit  EXTENDED = 1'b1,
   localparam int SEL_W    = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [SEL_W-1:0]                 wr_sel,
   input  logic [REG_W-1:0]                 wr_data,
   input  logic [SEL_W-1:0]                 rd_sel,
   output logic [REG_W-1:0]                 rd_data,
   output logic [NUM_REG-1:0][REG_W-1:0]    ctrl_q
);
   import fgen_pkg::*;

   localparam int FIELDS_BITS = GENS_PER_REG * FIELD_W;
   localparam logic [REG_W-1:0] FIELD_MASK = REG_W'((64'd1 << FIELDS_BITS) - 64'd1);
   localparam logic [REG_W-1:0] SCALE_MASK = EXTENDED ? REG_W'(64'd1 << SCALE_BIT) : '0;
   localparam logic [REG_W-1:0] KEEP_MASK  = FIELD_MASK | SCALE_MASK;

   if (FIELDS_BITS > SCALE_BIT) begin : g_bad_layout
      $error("fgen_regs: fields overlap the scale bit");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         ctrl_q[wr_sel] <= wr_data & KEEP_MASK;
      end
   end

   assign rd_data = ctrl_q[rd_sel];

   assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_sel != $past(wr_sel)) || (rd_data == ($past(wr_data) & KEEP_MASK)));

   assert_hold_without_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/fgen_decode.sv
module fgen_decode #(
   parameter bit EXTENDED = 1'b1
) (
   input  logic [fgen_pkg::FIELD_W-1:0] field,
   input  logic                         scale,
   output logic                         req_en,
   output logic [fgen_pkg::SRC_W-1:0]   req_src,
   output logic [fgen_pkg::CNT_W-1:0]   req_lim
);
   import fgen_pkg::*;

   logic [DIV_W-1:0] n_val;
   logic [CNT_W-1:0] lim_even;
   logic [CNT_W-1:0] lim_unit;

   assign n_val    = field[FIELD_W-1:2];
   assign lim_even = {n_val, 1'b1};   // (N+1)*2 - 1
   assign lim_unit = {1'b0, n_val};   // (N+1)   - 1

   if (EXTENDED) begin : g_ext
      always_comb begin
         req_en  = (field[1:0] != 2'd0);
         req_lim = scale ? lim_unit : lim_even;
         unique case (field[1:0])
            2'd1:    req_src = SRC_AUX2;
            2'd2:    req_src = SRC_CPU;
            2'd3:    req_src = SRC_AUX;
            default: req_src = SRC_CPU;
         endcase
      end
   end else begin : g_leg
      always_comb begin
         req_en  = field[1];
         req_src = field[0] ? SRC_AUX : SRC_CPU;
         req_lim = lim_even;
      end
   end
endmodule

// File: rtl/fgen_core.sv
module fgen_core (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [fgen_pkg::NUM_SRC-1:0]  src_ticks,
   input  logic                          req_en,
   input  logic [fgen_pkg::SRC_W-1:0]    req_src,
   input  logic [fgen_pkg::CNT_W-1:0]    req_lim,
   output logic                          tick_o,
   output logic                          wave_o
);
   import fgen_pkg::*;

   logic             act_en;
   logic [SRC_W-1:0] act_src;
   logic [CNT_W-1:0] act_lim;
   logic [CNT_W-1:0] cnt;
   logic             tick_q;
   logic             wave_q;
   logic             sel_tick;
   logic             at_end;

   always_comb begin
      sel_tick = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (act_src == SRC_W'(s)) sel_tick = src_ticks[s];
      end
   end

   assign at_end = (cnt == act_lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_en  <= 1'b0;
         act_src <= '0;
         act_lim <= '0;
         cnt     <= '0;
         tick_q  <= 1'b0;
         wave_q  <= 1'b0;
      end else if (!req_en) begin
         act_en <= 1'b0;
         cnt    <= '0;
         tick_q <= 1'b0;
         wave_q <= 1'b0;
      end else if (!act_en) begin
         act_en  <= 1'b1;
         act_src <= req_src;
         act_lim <= req_lim;
         cnt     <= '0;
         tick_q  <= 1'b0;
         wave_q  <= 1'b0;
      end else if (sel_tick && at_end) begin
         cnt     <= '0;
         tick_q  <= 1'b1;
         wave_q  <= ~wave_q;
         act_src <= req_src;
         act_lim <= req_lim;
      end else begin
         if (sel_tick) cnt <= cnt + 1'b1;
         tick_q <= 1'b0;
      end
   end

   assign tick_o = tick_q;
   assign wave_o = wave_q;

   assert_off_is_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !req_en |=> (!tick_o && !wave_o));

   assert_tick_follows_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> $past(sel_tick));

   assert_wave_moves_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(wave_o) && $past(req_en)) |-> tick_o);

   assert_config_held_mid_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(act_en) && $past(req_en) && !($past(sel_tick) && $past(at_end)))
         |-> ($stable(act_lim) && $stable(act_src)));

   assert_count_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      act_en |-> (cnt <= act_lim));
endmodule

// File: rtl/fgen_bank.sv
module fgen_bank #(
   parameter int  NUM_GEN  = 6,
   parameter int  REG_W    = 32,
   parameter bit  EXTENDED = 1'b1,
   localparam int NUM_REG  = NUM_GEN / fgen_pkg::GENS_PER_REG,
   localparam int SEL_W    = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_sel,
   input  logic [REG_W-1:0]   wr_data,
   input  logic [SEL_W-1:0]   rd_sel,
   output logic [REG_W-1:0]   rd_data,
   input  logic               cpu_tick,
   input  logic               aux_tick,
   input  logic               aux2_tick,
   output logic [NUM_GEN-1:0] gen_tick,
   output logic [NUM_GEN-1:0] gen_wave
);
   import fgen_pkg::*;

   if (NUM_GEN % GENS_PER_REG != 0 || NUM_GEN < GENS_PER_REG) begin : g_bad_count
      $error("fgen_bank: generator count must fill whole control words");
   end
   if (REG_W <= SCALE_BIT) begin : g_bad_width
      $error("fgen_bank: control word too narrow for the scale bit");
   end

   logic [NUM_REG-1:0][REG_W-1:0] ctrl_q;
   logic [NUM_SRC-1:0]            src_ticks;

   always_comb begin
      src_ticks           = '0;
      src_ticks[SRC_CPU]  = cpu_tick;
      src_ticks[SRC_AUX]  = aux_tick;
      src_ticks[SRC_AUX2] = aux2_tick;
   end

   fgen_regs #(
      .REG_W    (REG_W),
      .NUM_REG  (NUM_REG),
      .EXTENDED (EXTENDED)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .rd_sel  (rd_sel),
      .rd_data (rd_data),
      .ctrl_q  (ctrl_q)
   );

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      localparam int RIDX = g / GENS_PER_REG;
      localparam int LSB  = (g % GENS_PER_REG) * FIELD_W;

      logic             req_en;
      logic [SRC_W-1:0] req_src;
      logic [CNT_W-1:0] req_lim;

      fgen_decode #(.EXTENDED(EXTENDED)) u_dec (
         .field   (ctrl_q[RIDX][LSB +: FIELD_W]),
         .scale   (ctrl_q[RIDX][SCALE_BIT]),
         .req_en  (req_en),
         .req_src (req_src),
         .req_lim (req_lim)
      );

      fgen_core u_core (
         .clk       (clk),
         .rst_n     (rst_n),
         .src_ticks (src_ticks),
         .req_en    (req_en),
         .req_src   (req_src),
         .req_lim   (req_lim),
         .tick_o    (gen_tick[g]),
         .wave_o    (gen_wave[g])
      );
   end
endmodule

// File: tb/test_fgen_bank.sv
module test_fgen_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic        cpu_tick = 1'b1;
   logic        aux_tick = 1'b0;
   logic        aux2_tick = 1'b0;
   logic [31:0] rd_e, rd_l;
   logic [5:0]  tick_e, tick_l, wave_e, wave_l;
   int checks = 0;
   int errors = 0;
   logic [31:0] r0 = '0, r1 = '0;

   always #10 clk = ~clk;

   fgen_bank #(.EXTENDED(1'b1)) i_fgen_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_e), .cpu_tick(cpu_tick), .aux_tick(aux_tick),
      .aux2_tick(aux2_tick), .gen_tick(tick_e), .gen_wave(wave_e));

   fgen_bank #(.EXTENDED(1'b0)) i_fgen_bank_leg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_l), .cpu_tick(cpu_tick), .aux_tick(aux_tick),
      .aux2_tick(aux2_tick), .gen_tick(tick_l), .gen_wave(wave_l));

   // auxiliary source every 3 cycles, second auxiliary every 5 cycles
   initial begin
      int a = 0, b = 0;
      forever begin
         @(negedge clk);
         a = (a + 1) % 3;
         b = (b + 1) % 5;
         aux_tick  = (a == 0);
         aux2_tick = (b == 0);
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input bit sel, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic bit tk(input bit ext, input int g);
      return ext ? tick_e[g] : tick_l[g];
   endfunction

   task automatic wait_tick(input bit ext, input int g, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (tk(ext, g)) begin ok = 1'b1; break; end
      end
   endtask

   // spacing between output ticks, measured after skipping one period
   task automatic interval(input bit ext, input int g, output int n);
      bit ok;
      n = -1;
      wait_tick(ext, g, ok);
      if (!ok) return;
      wait_tick(ext, g, ok);
      if (!ok) return;
      n = 0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         n++;
         if (tk(ext, g)) return;
      end
      n = -1;
   endtask

   task automatic quiet(input bit ext, input int g, input int cyc, input string req);
      int hits = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         if (ext ? (tick_e[g] | wave_e[g]) : (tick_l[g] | wave_l[g])) hits++;
      end
      check(req, hits, 0);
   endtask

   task automatic t_reset;
      check("R10 reset rd0", rd_e, 0);
      check("R6 reset outputs", {tick_e, wave_e, tick_l, wave_l}, 0);
   endtask

   task automatic t_readback;
      wr(1'b0, 32'hFFFF_FFFF);
      rd_sel = 1'b0; #1;
      check("R10 ext rd0 mask", rd_e, 32'h7FFF_FFFF);
      check("R10 leg rd0 mask", rd_l, 32'h3FFF_FFFF);
      wr(1'b1, 32'hC000_0000);
      rd_sel = 1'b1; #1;
      check("R10 ext rd1 scale kept", rd_e, 32'h4000_0000);
      check("R10 leg rd1 scale dropped", rd_l, 32'h0);
      wr(1'b0, 32'h0);
      wr(1'b1, 32'h0);
      @(negedge clk);
      quiet(1'b1, 0, 20, "R6 ext gen0 off");
      quiet(1'b0, 2, 20, "R6 leg gen2 off");
   endtask

   task automatic t_cpu_even;
      int n, k;
      r0 = 32'h0000_000A;
      wr(1'b0, r0);
      k = 1;
      while (!tick_e[0] && k < 100) begin @(negedge clk); k++; end
      check("R6 ext first tick latency", k, 8);
      interval(1'b1, 0, n); check("R3 ext cpu ratio 6", n, 6);
      interval(1'b0, 0, n); check("R2 leg cpu ratio 6", n, 6);
      for (int g = 1; g < 6; g++) quiet(1'b1, g, 10, "R1 ext other fields idle");
   endtask

   task automatic t_aux;
      int n;
      r0 = 32'h0000_0C0A;
      wr(1'b0, r0);
      interval(1'b1, 1, n); check("R3 ext aux ratio 2 at period 3", n, 6);
      interval(1'b0, 1, n); check("R2 leg aux ratio 2 at period 3", n, 6);
      r1 = 32'h0000_0005;
      wr(1'b1, r1);
      interval(1'b1, 3, n); check("R3 ext aux2 ratio 4 at period 5", n, 20);
      quiet(1'b0, 3, 50, "R2 leg enable bit clear");
   endtask

   task automatic t_scale;
      int n;
      r1 = 32'h7FE0_0009;
      wr(1'b1, r1);
      interval(1'b1, 3, n); check("R4 ext scaled ratio 3 at period 5", n, 15);
      interval(1'b1, 5, n); check("R4 ext scaled max ratio 256", n, 256);
      interval(1'b0, 5, n); check("R2 leg max ratio 512", n, 512);
      r1 = 32'h7FE0_0809;
      wr(1'b1, r1);
      interval(1'b1, 4, n); check("R9 ext ratio 1", n, 1);
      begin
         int hi = 0;
         for (int i = 0; i < 10; i++) begin @(negedge clk); if (tick_e[4]) hi++; end
         check("R9 ext every source tick passes", hi, 10);
      end
      interval(1'b0, 4, n); check("R2 leg ratio 2 on cpu", n, 2);
   endtask

   task automatic t_boundary;
      bit ok;
      int k, n;
      wait_tick(1'b1, 0, ok);
      check("R5 ext gen0 running", ok, 1);
      r0 = (r0 & ~32'h3FF) | 32'h2;
      wr(1'b0, r0);
      k = 1;
      while (!tick_e[0] && k < 100) begin @(negedge clk); k++; end
      check("R7 old ratio finishes period", k, 6);
      check("R7 leg ticks in same cycle", tick_l[0], 1);
      n = 0;
      do begin @(negedge clk); n++; end while (!tick_e[0] && n < 100);
      check("R7 new ratio after boundary", n, 2);
      // disable mid period, then re-enable: count must restart
      r0 = (r0 & ~32'h3FF) | 32'h0A;
      wr(1'b0, r0);
      interval(1'b1, 0, n);
      @(negedge clk); @(negedge clk);
      wr(1'b0, r0 & ~32'h3FF);
      @(negedge clk);
      check("R6 disabled wave low", {tick_e[0], wave_e[0]}, 0);
      wr(1'b0, r0);
      k = 1;
      while (!tick_e[0] && k < 100) begin @(negedge clk); k++; end
      check("R6 count restarted", k, 8);
   endtask

   task automatic t_wave;
      int ticks = 0, flips = 0, stray = 0;
      logic prev;
      @(negedge clk);
      prev = wave_e[0];
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (tick_e[0]) ticks++;
         if (wave_e[0] != prev) begin
            flips++;
            if (!tick_e[0]) stray++;
         end
         prev = wave_e[0];
      end
      check("R8 ticks in 60 cycles at ratio 6", ticks, 10);
      check("R8 wave flips per tick", flips, ticks);
      check("R8 no flip without tick", stray, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_cpu_even();
      t_aux();
      t_scale();
      t_boundary();
      t_wave();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule